// File: doc/BRIEF.md
# Edge-Gated Platform Interrupt Controller

This block collects interrupt request lines from peripherals and presents one interrupt output to each of several processor contexts. Each source has a programmable priority, and the block keeps one pending bit per source. Each context has its own enable bits and a priority threshold. A context's output is raised while at least one source is pending, enabled for that context and above its threshold. Software takes an interrupt by reading the context's claim register and releases it by writing the same source ID back to that register.

Each source enters through an edge-sensitive gateway that records a request only on a rising edge of its line. After a claim, the gateway forwards nothing until completion. A line that is still high at completion therefore produces no new request until it falls and rises again. Source ID 0 stands for "no interrupt" and has no line. On the target platform, general-purpose input pin n is wired to source ID 23+n.

Register map, byte addresses, 32-bit words. Priority of source i is at 4*i and uses the low PRIO_W bits. Pending word w is at 0x1000+4*w. Enable word w of context c is at 0x2100+0x100*c+4*w. The threshold of context c is at 0x202000+0x2000*c, and its claim/complete register is at that address plus 8. Source i is bit i%32 of word i/32.

Top module: `irq_hub`

## Requirements
- R1: After reset, all pending bits, priorities, enables and thresholds read as zero. Every context output is low, and a claim returns 0.
- R2: A rising edge on the line of source i (a clock edge with the line high after one with it low) sets pending bit i, which is bit i%32 of the word at 0x1000+4*(i/32). The bit is visible after that edge.
- R3: A line that stays high after its request is claimed and completed creates no new pending request.
- R4: Source ID 0 can never become pending. Its priority register and its enable bit 0 read back as zero whatever is written to them.
- R5: Output irq[c] is high exactly when some pending source that is enabled for context c has a priority strictly greater than the threshold of context c. Outputs follow register changes after one clock edge.
- R6: A read of the claim register of context c returns the ID of the eligible source with the highest priority, taking the lowest ID on a tie, and returns 0 when none is eligible. Read data appears on bus_rdata after the edge that accepts the read.
- R7: A claim clears the claimed source's pending bit. While the source is in service, rising edges on its line are dropped and are not remembered.
- R8: Writing a source ID to any claim/complete register ends service for that source. The next rising edge on its line sets it pending again.
- R9: Priority, enable and threshold registers read back what was written. The pending words are read-only, and writes to them have no effect.
- R10: A source with priority 0 may be pending but never raises an output and is never returned by a claim.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_lines | input | NUM_SRC-1 | Request lines, bit i for source ID i (1..NUM_SRC-1), synchronous to clk |
| bus_valid | input | 1 | Register access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 24 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered on the accepting edge |
| irq | output | NUM_CTX | Interrupt output per context |

## Verification
The assertions assume that the request lines are already synchronous to clk, that each bus access lasts a single cycle, and that software completes only IDs it has claimed. The bench changes lines only on falling clock edges and holds every bus strobe for exactly one cycle with an idle cycle between accesses. It writes complete only for sources the bench has just claimed, except for one deliberate write that follows a claim. Reset is held for several cycles with all lines low, so the edge-history checks begin from a known line state.

// File: rtl/irq_hub_pkg.sv
// Package: address map constants and address helpers shared by the
// interrupt hub, its checker and its bench. Assumes 24-bit byte addresses
// and 32-bit data words.
package irq_hub_pkg;
    localparam int ADDR_W     = 24;
    localparam int DATA_W     = 32;
    localparam int PEND_BASE  = 32'h0000_1000;
    localparam int EN_BASE    = 32'h0000_2100;
    localparam int EN_STRIDE  = 32'h0000_0100;
    localparam int THR_BASE   = 32'h0020_2000;
    localparam int THR_STRIDE = 32'h0000_2000;
    localparam int CLAIM_OFS  = 8;

    function automatic logic [ADDR_W-1:0] prio_addr(input int id);
        return ADDR_W'(4 * id);
    endfunction

    function automatic logic [ADDR_W-1:0] pend_addr(input int w);
        return ADDR_W'(PEND_BASE + 4 * w);
    endfunction

    function automatic logic [ADDR_W-1:0] en_addr(input int c, input int w);
        return ADDR_W'(EN_BASE + EN_STRIDE * c + 4 * w);
    endfunction

    function automatic logic [ADDR_W-1:0] thr_addr(input int c);
        return ADDR_W'(THR_BASE + THR_STRIDE * c);
    endfunction

    function automatic logic [ADDR_W-1:0] claim_addr(input int c);
        return ADDR_W'(THR_BASE + THR_STRIDE * c + CLAIM_OFS);
    endfunction
endpackage

// File: rtl/irq_gateway.sv
// Edge gateway for one interrupt source. It records a request on a rising
// edge of the line, holds it as pending until a claim, then blocks further
// requests until completion. Edges that arrive while pending or in service
// are dropped. Assumes the line is synchronous to clk.
module irq_gateway (
    input  logic clk,
    input  logic rst_n,
    input  logic line,
    input  logic claim,
    input  logic complete,
    output logic pend,
    output logic insvc
);
    logic line_d;

    // Line history, pending flag and in-service flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_d <= 1'b0;
            pend   <= 1'b0;
            insvc  <= 1'b0;
        end else begin
            line_d <= line;
            if (claim) begin
                pend  <= 1'b0;
                insvc <= 1'b1;
            end else begin
                if (complete)
                    insvc <= 1'b0;
                if (line && !line_d && !insvc)
                    pend <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/irq_target.sv
// Target selection for one context. It picks the pending, enabled source
// whose priority is above the threshold and highest of all, with the lower
// ID winning ties, and raises irq when one exists. Assumes that slot 0 of
// every vector is zero.
module irq_target #(
    parameter int NUM_SRC = 48,
    parameter int PRIO_W  = 3,
    parameter int ID_W    = 6
) (
    input  logic [NUM_SRC-1:0]        pend,
    input  logic [NUM_SRC-1:0]        en,
    input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
    input  logic [PRIO_W-1:0]         thr,
    output logic [ID_W-1:0]           best_id,
    output logic                      irq
);
    logic [PRIO_W-1:0] best_p;
    logic [PRIO_W-1:0] p;

    // Linear scan for the winning source. The strict compare keeps the lowest ID on a tie.
    always_comb begin
        best_p  = '0;
        best_id = '0;
        p       = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            p = prio_flat[i*PRIO_W +: PRIO_W];
            if (pend[i] && en[i] && (p > thr) && (p > best_p)) begin
                best_p  = p;
                best_id = ID_W'(i);
            end
        end
    end

    // Output request whenever a winner exists.
    always_comb irq = (best_id != '0);
endmodule

// File: rtl/irq_hub.sv
// Interrupt hub top level. It holds the per-source priorities, the
// per-context enables and thresholds, one gateway per source and one
// target per context, and decodes a single-cycle register bus. Reads are
// registered, and a read of a claim register takes the current winner.
// Assumes NUM_SRC <= 96 (three pending words) and synchronous request lines.
module irq_hub
    import irq_hub_pkg::*;
#(
    parameter int NUM_SRC = 48,
    parameter int NUM_CTX = 2,
    parameter int PRIO_W  = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SRC-1:1]   src_lines,
    input  logic                 bus_valid,
    input  logic                 bus_write,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic [NUM_CTX-1:0]   irq
);
    localparam int ID_W   = $clog2(NUM_SRC);
    localparam int NWORDS = (NUM_SRC + 31) / 32;

    logic [PRIO_W-1:0]        prio_q [NUM_SRC];
    logic [NUM_SRC-1:1]       en_q   [NUM_CTX];
    logic [PRIO_W-1:0]        thr_q  [NUM_CTX];
    logic [NUM_SRC-1:0]       pend_vec;
    logic [NUM_SRC-1:0]       insvc_vec;
    logic [NUM_SRC-1:1]       claim_vec;
    logic [NUM_SRC-1:1]       complete_vec;
    logic [NUM_SRC*PRIO_W-1:0] prio_flat;
    logic [ID_W-1:0]          best_id [NUM_CTX];
    logic [DATA_W-1:0]        rd_next;
    logic                     rd_req;
    logic                     wr_req;

    assign rd_req = bus_valid && !bus_write;
    assign wr_req = bus_valid &&  bus_write;

    // ID 0 has no gateway.
    assign pend_vec[0]  = 1'b0;
    assign insvc_vec[0] = 1'b0;

    // One gateway per real source.
    for (genvar g = 1; g < NUM_SRC; g++) begin : g_gw
        irq_gateway u_gw (
            .clk      (clk),
            .rst_n    (rst_n),
            .line     (src_lines[g]),
            .claim    (claim_vec[g]),
            .complete (complete_vec[g]),
            .pend     (pend_vec[g]),
            .insvc    (insvc_vec[g])
        );
    end

    // Flatten priorities for the targets. Slot 0 always holds zero.
    always_comb begin
        for (int i = 0; i < NUM_SRC; i++)
            prio_flat[i*PRIO_W +: PRIO_W] = prio_q[i];
    end

    // One target per context.
    for (genvar c = 0; c < NUM_CTX; c++) begin : g_tgt
        irq_target #(
            .NUM_SRC (NUM_SRC),
            .PRIO_W  (PRIO_W),
            .ID_W    (ID_W)
        ) u_tgt (
            .pend      (pend_vec),
            .en        ({en_q[c], 1'b0}),
            .prio_flat (prio_flat),
            .thr       (thr_q[c]),
            .best_id   (best_id[c]),
            .irq       (irq[c])
        );
    end

    // Claim strobes: a claim read takes the winner of its context.
    always_comb begin
        claim_vec = '0;
        for (int c = 0; c < NUM_CTX; c++) begin
            if (rd_req && bus_addr == claim_addr(c)) begin
                for (int i = 1; i < NUM_SRC; i++)
                    if (best_id[c] == ID_W'(i))
                        claim_vec[i] = 1'b1;
            end
        end
    end

    // Complete strobes: the written ID releases its gateway.
    always_comb begin
        complete_vec = '0;
        for (int c = 0; c < NUM_CTX; c++) begin
            if (wr_req && bus_addr == claim_addr(c)) begin
                for (int i = 1; i < NUM_SRC; i++)
                    if (bus_wdata == DATA_W'(i))
                        complete_vec[i] = 1'b1;
            end
        end
    end

    // Priority registers. Slot 0 stays zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_SRC; i++)
                prio_q[i] <= '0;
        end else if (wr_req) begin
            for (int i = 1; i < NUM_SRC; i++)
                if (bus_addr == prio_addr(i))
                    prio_q[i] <= bus_wdata[PRIO_W-1:0];
        end
    end

    // Enable bits and thresholds per context.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NUM_CTX; c++) begin
                en_q[c]  <= '0;
                thr_q[c] <= '0;
            end
        end else if (wr_req) begin
            for (int c = 0; c < NUM_CTX; c++) begin
                for (int i = 1; i < NUM_SRC; i++)
                    if (bus_addr == en_addr(c, i / 32))
                        en_q[c][i] <= bus_wdata[i % 32];
                if (bus_addr == thr_addr(c))
                    thr_q[c] <= bus_wdata[PRIO_W-1:0];
            end
        end
    end

    // Read data selection.
    always_comb begin
        rd_next = '0;
        for (int i = 1; i < NUM_SRC; i++)
            if (bus_addr == prio_addr(i))
                rd_next = DATA_W'(prio_q[i]);
        for (int i = 1; i < NUM_SRC; i++)
            if (bus_addr == pend_addr(i / 32))
                rd_next[i % 32] = pend_vec[i];
        for (int c = 0; c < NUM_CTX; c++) begin
            for (int i = 1; i < NUM_SRC; i++)
                if (bus_addr == en_addr(c, i / 32))
                    rd_next[i % 32] = en_q[c][i];
            if (bus_addr == thr_addr(c))
                rd_next = DATA_W'(thr_q[c]);
            if (bus_addr == claim_addr(c))
                rd_next = DATA_W'(best_id[c]);
        end
    end

    // Registered read data, updated only on an accepted read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bus_rdata <= '0;
        else if (rd_req)
            bus_rdata <= rd_next;
    end

    initial begin
        if (NUM_SRC > 32 * 3 || NWORDS > 3)
            $error("irq_hub: NUM_SRC exceeds three pending words");
    end
endmodule

// File: rtl/irq_hub_checker.sv
// Property checker for the interrupt hub, attached by bind. It observes
// the ports plus the pending and in-service vectors that the gateways drive.
// Assumes single-cycle bus accesses and request lines synchronous to clk.
module irq_hub_checker
    import irq_hub_pkg::*;
#(
    parameter int NUM_SRC = 48,
    parameter int NUM_CTX = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_SRC-1:1]   src_lines,
    input logic                 bus_valid,
    input logic                 bus_write,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [DATA_W-1:0]    bus_rdata,
    input logic [NUM_CTX-1:0]   irq,
    input logic [NUM_SRC-1:0]   pend_vec,
    input logic [NUM_SRC-1:0]   insvc_vec
);
    localparam int ID_W = $clog2(NUM_SRC);

    logic       seen;
    logic       rst_n_d;
    logic [1:0] run_cnt;
    logic       claim_rd_d;
    logic       is_claim;

    // Decode a claim read on the bus.
    always_comb begin
        is_claim = 1'b0;
        for (int c = 0; c < NUM_CTX; c++)
            if (bus_valid && !bus_write && bus_addr == claim_addr(c))
                is_claim = 1'b1;
    end

    // History flags: first-edge marker, previous reset level, cycles since release, last claim.
    always_ff @(posedge clk) begin
        seen       <= 1'b1;
        rst_n_d    <= rst_n;
        claim_rd_d <= rst_n && is_claim;
        if (!rst_n)
            run_cnt <= '0;
        else if (run_cnt != 2'd3)
            run_cnt <= run_cnt + 2'd1;
    end

    // R1: the cycle after reset is quiet.
    a_r1_reset_quiet: assert property (@(posedge clk)
        (seen && !rst_n_d) |-> (pend_vec == '0 && insvc_vec == '0 && irq == '0));

    // R2 and R3: a pending bit rises only on a recorded low-then-high line.
    a_r3_edge_only: assert property (@(posedge clk) disable iff (!rst_n)
        (run_cnt >= 2'd2) |->
        ((pend_vec[NUM_SRC-1:1] & ~$past(pend_vec[NUM_SRC-1:1])
          & ~($past(src_lines) & ~$past(src_lines, 2))) == '0));

    // R5: no output without some pending source.
    a_r5_irq_needs_pend: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq) |-> (|pend_vec));

    // R7: a source is never pending and in service together.
    a_r7_pend_excl_insvc: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_vec & insvc_vec) == '0);

    // R7: the ID just claimed is in service and no longer pending.
    a_r7_claim_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (claim_rd_d && bus_rdata != '0 && bus_rdata < DATA_W'(NUM_SRC)) |->
        (insvc_vec[bus_rdata[ID_W-1:0]] && !pend_vec[bus_rdata[ID_W-1:0]]));
endmodule

bind irq_hub irq_hub_checker #(
    .NUM_SRC (NUM_SRC),
    .NUM_CTX (NUM_CTX)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_lines (src_lines),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .pend_vec  (pend_vec),
    .insvc_vec (insvc_vec)
);

// File: tb/tb_irq_hub.sv
// Scoreboard bench: read tasks push expected words into a queue and a
// monitor pops and compares them when the registered read data appears.
module tb_irq_hub;
    import irq_hub_pkg::*;

    localparam int NSRC = 48;
    localparam int NCTX = 2;
    localparam int PW   = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NSRC-1:1]   src = '0;
    logic              bus_valid = 1'b0;
    logic              bus_write = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic [NCTX-1:0]   irq;

    int n_run  = 0;
    int n_fail = 0;
    logic rd_seen = 1'b0;
    logic [DATA_W-1:0] exp_q [$];
    string             tag_q [$];

    always #10 clk = ~clk;

    irq_hub #(.NUM_SRC(NSRC), .NUM_CTX(NCTX), .PRIO_W(PW)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_lines (src),
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    // Mark cycles whose edge accepted a read.
    always @(posedge clk) rd_seen <= bus_valid && !bus_write;

    // Monitor: compare registered read data with the scoreboard head.
    always @(negedge clk) begin
        if (rd_seen && exp_q.size() > 0) begin
            logic [DATA_W-1:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_run++;
            if (bus_rdata !== e) begin
                n_fail++;
                $display("FAIL %s: rdata actual %h expected %h", t, bus_rdata, e);
            end
        end
    end

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    task automatic chk_irq(input logic [NCTX-1:0] e, input string t);
        n_run++;
        if (irq !== e) begin
            n_fail++;
            $display("FAIL %s: irq actual %b expected %b", t, irq, e);
        end
    endtask

    task automatic line(input int i, input logic v);
        @(negedge clk);
        src[i] = v;
        @(negedge clk);
    endtask

    task automatic finish_run;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk_irq(2'b00, "R1 irq after reset");
        rd(pend_addr(0), 32'h0, "R1 pending word 0");
        rd(pend_addr(1), 32'h0, "R1 pending word 1");
        rd(prio_addr(5), 32'h0, "R1 priority 5");
        rd(en_addr(0, 0), 32'h0, "R1 enable ctx0");
        rd(claim_addr(0), 32'h0, "R1 empty claim");

        // Programming and readback
        wr(prio_addr(5), 3);
        wr(prio_addr(24), 3);
        wr(prio_addr(40), 6);
        wr(prio_addr(0), 7);
        rd(prio_addr(0), 32'h0, "R4 priority of ID 0");
        rd(prio_addr(40), 32'h6, "R9 priority readback");
        wr(pend_addr(0), 32'hFFFF_FFFF);
        rd(pend_addr(0), 32'h0, "R9 pending read-only");
        wr(en_addr(0, 0), 32'h0100_00A1);
        wr(en_addr(0, 1), 32'h0000_0100);
        wr(en_addr(1, 1), 32'h0000_0100);
        rd(en_addr(0, 0), 32'h0100_00A0, "R4 enable bit 0 stuck low");
        rd(en_addr(1, 1), 32'h0000_0100, "R9 enable readback");

        // Priority 0 source pends but is ignored
        line(7, 1'b1);
        rd(pend_addr(0), 32'h0000_0080, "R2 pending after edge");
        chk_irq(2'b00, "R10 priority 0 no irq");

        // Two sources with equal priority
        @(negedge clk);
        src[5] = 1'b1; src[24] = 1'b1;
        @(negedge clk);
        chk_irq(2'b01, "R5 ctx0 only");
        rd(pend_addr(0), 32'h0100_00A0, "R2 two pending");
        rd(claim_addr(0), 32'd5, "R6 tie lowest ID");
        rd(pend_addr(0), 32'h0100_0080, "R7 claim clears pending");
        rd(claim_addr(0), 32'd24, "R6 second claim");
        chk_irq(2'b00, "R10 only priority 0 left");
        rd(claim_addr(0), 32'd0, "R10 claim skips priority 0");

        // Complete while lines stay high
        wr(claim_addr(0), 5);
        wr(claim_addr(0), 24);
        repeat (3) @(negedge clk);
        rd(pend_addr(0), 32'h0000_0080, "R3 held line no re-request");
        chk_irq(2'b00, "R3 no irq from held line");

        // Fresh edge after completion
        line(5, 1'b0);
        line(5, 1'b1);
        rd(pend_addr(0), 32'h0000_00A0, "R8 new edge after complete");
        chk_irq(2'b01, "R8 irq again");

        // Edges during service are dropped
        rd(claim_addr(0), 32'd5, "R6 claim 5 again");
        line(5, 1'b0);
        line(5, 1'b1);
        rd(pend_addr(0), 32'h0000_0080, "R7 edge in service dropped");
        wr(claim_addr(0), 5);
        rd(pend_addr(0), 32'h0000_0080, "R7 dropped edge not remembered");
        line(5, 1'b0);
        line(5, 1'b1);
        rd(pend_addr(0), 32'h0000_00A0, "R8 edge after release");
        rd(claim_addr(0), 32'd5, "R6 claim 5 third time");
        wr(claim_addr(0), 5);

        // Threshold is strict
        line(40, 1'b1);
        rd(pend_addr(1), 32'h0000_0100, "R2 pending word 1 bit 8");
        chk_irq(2'b11, "R5 both contexts");
        wr(thr_addr(1), 6);
        chk_irq(2'b01, "R5 threshold equal blocks");
        rd(thr_addr(1), 32'h6, "R9 threshold readback");
        wr(thr_addr(1), 5);
        chk_irq(2'b11, "R5 threshold below passes");
        rd(claim_addr(1), 32'd40, "R6 claim ctx1");
        chk_irq(2'b00, "R5 after claim");
        rd(pend_addr(1), 32'h0, "R7 word 1 cleared");
        wr(claim_addr(1), 40);

        // Higher priority beats lower ID
        @(negedge clk);
        src[24] = 1'b0; src[40] = 1'b0;
        @(negedge clk);
        src[24] = 1'b1; src[40] = 1'b1;
        @(negedge clk);
        rd(claim_addr(0), 32'd40, "R6 priority beats ID");
        rd(claim_addr(0), 32'd24, "R6 then lower priority");
        wr(claim_addr(0), 40);
        wr(claim_addr(0), 24);
        wr(claim_addr(0), 0);
        chk_irq(2'b00, "R4 complete of ID 0 harmless");
        rd(pend_addr(0), 32'h0000_0080, "R4 ID 0 never pending");

        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule